// File: doc/BRIEF.md
# Wavelength Lane Rotation Mapper

This block sits between a set of parallel electrical data lanes and the same number of wavelength channels on an optical link. After calibration, each ring resonator serves whichever channel lies nearest to it rather than a fixed channel. The lane-to-channel assignment is therefore a cyclic rotation by an offset that is only known once tuning has finished. The block holds that offset and applies it in both directions. On the transmit side it spreads logical lanes onto physical channels. On the receive side it applies the exact inverse, so data leaves the far end in its original lane order.

A calibration port writes the offset while the link is down. While the link-enable input is high, the offset is frozen and load requests are discarded. Both directions use a combinational rotator followed by one register stage. Each direction carries its own valid flag alongside its data. With a zero offset the block is a plain one-cycle pipeline.

Top module: `wdm_lane_rotator`

## Requirements
- R1: After reset, both valid outputs are 0, both data outputs are all zeros, and the stored offset is 0.
- R2: When txValidIn is high at a clock edge, the field at bits [c*LANE_W +: LANE_W] of txChans after that edge equals the field at bits [i*LANE_W +: LANE_W] of txLanes, where c = (i + k) mod NUM_CH and k is the stored offset at that edge.
- R3: When rxValidIn is high at a clock edge, the field at bits [i*LANE_W +: LANE_W] of rxLanes after that edge equals the field at bits [c*LANE_W +: LANE_W] of rxChans, where c = (i + k) mod NUM_CH.
- R4: txValidOut and rxValidOut equal txValidIn and rxValidIn as sampled at the previous clock edge, giving exactly one cycle of latency in each direction.
- R5: While a direction's valid input is low, that direction's data output holds its last value.
- R6: When cfgLoad is high and linkEn is low at a clock edge, cfgOffset becomes the stored offset. Data captured at that same edge still uses the previous offset. Data captured at later edges uses the new offset.
- R7: When linkEn is high, cfgLoad is ignored and the stored offset, and therefore the mapping, is unchanged.
- R8: With an offset of 0, every lane passes straight through to the channel of the same index in both directions.
- R9: Rotation indices wrap modulo NUM_CH. Feeding txChans and txValidOut back into rxChans and rxValidIn returns the original lanes in order for every offset from 0 to NUM_CH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLoad | input | 1 | Offset load request |
| cfgOffset | input | OFS_W | Offset value to load |
| linkEn | input | 1 | Link active; blocks offset loads |
| txValidIn | input | 1 | Transmit lanes valid |
| txLanes | input | NUM_CH*LANE_W | Logical transmit lanes, lane i at [i*LANE_W +: LANE_W] |
| txValidOut | output | 1 | Transmit channels valid |
| txChans | output | NUM_CH*LANE_W | Physical transmit channels |
| rxValidIn | input | 1 | Received channels valid |
| rxChans | input | NUM_CH*LANE_W | Physical received channels |
| rxValidOut | output | 1 | Restored lanes valid |
| rxLanes | output | NUM_CH*LANE_W | Logical receive lanes in original order |

## Verification
The bench uses offsets 0, 3 and NUM_CH-1, where the largest offset exercises wrap-around. A rotator that dropped the modulo step would address past the top channel, and one rotating the wrong way would scramble lanes. A load issued together with valid data checks that the in-flight word uses the old offset; a design loading one cycle early would rotate that word by the new value. A load attempted while the link is enabled must leave the mapping untouched, and a design that ignores the enable would show the new rotation at the outputs. A loopback sweep through every offset confirms that the receive rotation exactly inverts the transmit rotation, and idle gaps between words confirm that outputs hold their last value.

// File: rtl/wdm_rot_pkg.sv
package wdm_rot_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic txStep;
    logic rxStep;
  } step_t;
endpackage

// File: rtl/wdm_rot_shift.sv
module wdm_rot_shift #(
  parameter int NUM_CH  = 8,
  parameter int LANE_W  = 8,
  parameter int OFS_W   = 3,
  parameter bit INVERSE = 1'b0
) (
  input  logic [NUM_CH*LANE_W-1:0] dIn,
  input  logic [OFS_W-1:0]         amt,
  output logic [NUM_CH*LANE_W-1:0] dOut
);
  for (genvar j = 0; j < NUM_CH; j++) begin : g_pos
    localparam logic [OFS_W-1:0] POS = OFS_W'(j);
    logic [OFS_W-1:0] srcIdx;
    if (INVERSE) begin : g_inv
      // output lane j reads channel (j + k) mod N
      assign srcIdx = POS + amt;
    end else begin : g_fwd
      // output channel j reads lane (j - k) mod N
      assign srcIdx = POS - amt;
    end
    assign dOut[j*LANE_W +: LANE_W] = dIn[srcIdx*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/wdm_rot_ctrl.sv
module wdm_rot_ctrl
  import wdm_rot_pkg::*;
#(
  parameter int OFS_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [OFS_W-1:0] cfgOffset,
  input  logic             linkEn,
  input  logic             txValidIn,
  input  logic             rxValidIn,
  output step_t            steps,
  output logic [OFS_W-1:0] offset
);
  logic offsetUpd;
  assign offsetUpd = cfgLoad && !linkEn;

  always_ff @(posedge clk) begin
    if (!rstN) offset <= '0;
    else if (offsetUpd) offset <= cfgOffset;
  end

  always_comb begin
    steps.txStep = txValidIn;
    steps.rxStep = rxValidIn;
  end

  // R6
  load_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgLoad && !linkEn) |=> (offset == $past(cfgOffset)));
  // R7
  frozen_when_linked_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkEn |=> $stable(offset));
endmodule

// File: rtl/wdm_rot_dpath.sv
module wdm_rot_dpath
  import wdm_rot_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LANE_W = 8,
  parameter int OFS_W  = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  step_t                    steps,
  input  logic [OFS_W-1:0]         offset,
  input  logic [NUM_CH*LANE_W-1:0] txLanes,
  input  logic [NUM_CH*LANE_W-1:0] rxChans,
  output logic                     txValidOut,
  output logic [NUM_CH*LANE_W-1:0] txChans,
  output logic                     rxValidOut,
  output logic [NUM_CH*LANE_W-1:0] rxLanes
);
  logic [NUM_CH*LANE_W-1:0] txRot, rxRot;

  wdm_rot_shift #(.NUM_CH(NUM_CH), .LANE_W(LANE_W), .OFS_W(OFS_W), .INVERSE(1'b0))
    uTxShift (.dIn(txLanes), .amt(offset), .dOut(txRot));
  wdm_rot_shift #(.NUM_CH(NUM_CH), .LANE_W(LANE_W), .OFS_W(OFS_W), .INVERSE(1'b1))
    uRxShift (.dIn(rxChans), .amt(offset), .dOut(rxRot));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txValidOut <= 1'b0;
      rxValidOut <= 1'b0;
      txChans    <= '0;
      rxLanes    <= '0;
    end else begin
      txValidOut <= steps.txStep;
      rxValidOut <= steps.rxStep;
      if (steps.txStep) txChans <= txRot;
      if (steps.rxStep) rxLanes <= rxRot;
    end
  end

  // R4
  tx_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    steps.txStep |=> txValidOut);
  // R4
  rx_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    !steps.rxStep |=> !rxValidOut);
  // R5
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !steps.txStep |=> $stable(txChans));
  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !steps.rxStep |=> $stable(rxLanes));
endmodule

// File: rtl/wdm_lane_rotator.sv
module wdm_lane_rotator
  import wdm_rot_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int LANE_W = 8
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  cfgLoad,
  input  logic [$clog2(NUM_CH)-1:0]             cfgOffset,
  input  logic                                  linkEn,
  input  logic                                  txValidIn,
  input  logic [NUM_CH*LANE_W-1:0]              txLanes,
  output logic                                  txValidOut,
  output logic [NUM_CH*LANE_W-1:0]              txChans,
  input  logic                                  rxValidIn,
  input  logic [NUM_CH*LANE_W-1:0]              rxChans,
  output logic                                  rxValidOut,
  output logic [NUM_CH*LANE_W-1:0]              rxLanes
);
  localparam int OFS_W = $clog2(NUM_CH);

  step_t            steps;
  logic [OFS_W-1:0] offset;

  wdm_rot_ctrl #(.OFS_W(OFS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgOffset(cfgOffset),
    .linkEn(linkEn), .txValidIn(txValidIn), .rxValidIn(rxValidIn),
    .steps(steps), .offset(offset)
  );

  wdm_rot_dpath #(.NUM_CH(NUM_CH), .LANE_W(LANE_W), .OFS_W(OFS_W)) uDpath (
    .clk(clk), .rstN(rstN), .steps(steps), .offset(offset),
    .txLanes(txLanes), .rxChans(rxChans),
    .txValidOut(txValidOut), .txChans(txChans),
    .rxValidOut(rxValidOut), .rxLanes(rxLanes)
  );
endmodule

// File: tb/wdm_lane_rotator_test.sv
module wdm_lane_rotator_test;
  localparam int N = 8;
  localparam int W = 8;
  localparam int KW = 3;
  localparam time PERIOD = 10;
  localparam int BW = N*W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgLoad = 1'b0, linkEn = 1'b0, txValidIn = 1'b0, rxVd = 1'b0, loopMode = 1'b0;
  logic [KW-1:0] cfgOffset = '0;
  logic [BW-1:0] txLanes = '0, rxDrive = '0;
  logic txValidOut, rxValidOut, rxValidIn;
  logic [BW-1:0] txChans, rxLanes, rxChans;

  assign rxChans   = loopMode ? txChans : rxDrive;
  assign rxValidIn = loopMode ? txValidOut : rxVd;

  always #(PERIOD/2) clk = ~clk;

  wdm_lane_rotator #(.NUM_CH(N), .LANE_W(W)) uut (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgOffset(cfgOffset), .linkEn(linkEn),
    .txValidIn(txValidIn), .txLanes(txLanes), .txValidOut(txValidOut), .txChans(txChans),
    .rxValidIn(rxValidIn), .rxChans(rxChans), .rxValidOut(rxValidOut), .rxLanes(rxLanes)
  );

  int errors = 0, checks = 0;
  int tbOffset = 0;
  logic expTxV = 1'b0, expRxV = 1'b0;
  logic [BW-1:0] txQ[$], rxQ[$];
  logic [BW-1:0] lastTx = '0, lastRx = '0;
  bit monOn = 1'b0;

  function automatic logic [BW-1:0] fwdMap(logic [BW-1:0] d, int k);
    logic [BW-1:0] o;
    for (int i = 0; i < N; i++) o[((i+k)%N)*W +: W] = d[i*W +: W];
    return o;
  endfunction

  function automatic logic [BW-1:0] invMap(logic [BW-1:0] d, int k);
    logic [BW-1:0] o;
    for (int i = 0; i < N; i++) o[i*W +: W] = d[((i+k)%N)*W +: W];
    return o;
  endfunction

  function automatic logic [BW-1:0] pat(int seed);
    logic [BW-1:0] o;
    for (int i = 0; i < N; i++) o[i*W +: W] = W'(seed*31 + i*17 + 5);
    return o;
  endfunction

  task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, pushes expectations
  task automatic step(bit tv, logic [BW-1:0] td, bit rv, logic [BW-1:0] rd,
                      bit ld, int ko, bit le, string req);
    @(negedge clk);
    txValidIn = tv; txLanes = td; rxVd = rv; rxDrive = rd;
    cfgLoad = ld; cfgOffset = KW'(ko); linkEn = le;
    expTxV = tv;
    expRxV = loopMode ? expRxV : rv;
    if (tv) txQ.push_back(fwdMap(td, tbOffset));
    if (tv && loopMode) rxQ.push_back(td);
    if (rv && !loopMode) rxQ.push_back(invMap(rd, tbOffset));
    if (ld && !le) tbOffset = ko;
    if (req.len() == 0) ;
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) step(0, '0, 0, '0, 0, 0, linkEn, "");
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk); #1;
      if (monOn) begin
        if (!loopMode) begin
          checks++;
          if (txValidOut !== expTxV || rxValidOut !== expRxV) begin
            errors++;
            $display("FAIL R4 actual=%b%b expected=%b%b", txValidOut, rxValidOut, expTxV, expRxV);
          end
        end
        if (txValidOut) begin
          if (txQ.size() == 0) check("R2 spurious tx", txChans, 'x);
          else begin lastTx = txQ.pop_front(); check("R2 tx map", txChans, lastTx); end
        end else check("R5 tx hold", txChans, lastTx);
        if (rxValidOut) begin
          if (rxQ.size() == 0) check("R3 spurious rx", rxLanes, 'x);
          else begin lastRx = rxQ.pop_front(); check("R3/R9 rx map", rxLanes, lastRx); end
        end else check("R5 rx hold", rxLanes, lastRx);
      end
    end
  end

  initial begin
    #(PERIOD*200000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    check("R1 txValidOut", BW'(txValidOut), '0);
    check("R1 rxValidOut", BW'(rxValidOut), '0);
    check("R1 txChans", txChans, '0);
    check("R1 rxLanes", rxLanes, '0);
    monOn = 1'b1;

    // R8 offset 0 passthrough (expected equals input)
    step(1, pat(1), 1, pat(2), 0, 0, 0, "R8");
    step(1, pat(3), 0, '0, 0, 0, 0, "R8");
    idle(2);
    check("R8 straight", txChans, pat(3));
    check("R8 straight rx", rxLanes, pat(2));

    // R6 load 3 while sending: same-edge word uses old offset 0
    step(1, pat(4), 1, pat(5), 1, 3, 0, "R6");
    step(1, pat(6), 1, pat(7), 0, 0, 0, "R2");
    idle(1);
    step(1, pat(8), 0, '0, 0, 0, 0, "R2");
    idle(2);
    check("R6 new offset tx", txChans, fwdMap(pat(8), 3));

    // R9 wrap offset N-1
    step(0, '0, 0, '0, 1, N-1, 0, "R9");
    step(1, pat(9), 1, pat(10), 0, 0, 0, "R9");
    step(1, pat(11), 1, pat(12), 0, 0, 0, "R9");
    idle(2);

    // R7 load attempt while linked is ignored
    step(0, '0, 0, '0, 1, 5, 1, "R7");
    step(1, pat(13), 1, pat(14), 0, 0, 1, "R7");
    idle(2);
    check("R7 offset kept", txChans, fwdMap(pat(13), N-1));
    step(0, '0, 0, '0, 0, 0, 0, "");
    idle(1);

    // R9 loopback at every offset
    for (int k = 0; k < N; k++) begin
      step(0, '0, 0, '0, 1, k, 0, "R9");
      loopMode = 1'b1;
      step(1, pat(20+k), 0, '0, 0, 0, 0, "R9");
      step(1, pat(40+k), 0, '0, 0, 0, 0, "R9");
      idle(4);
      check("R9 loopback", rxLanes, pat(40+k));
      loopMode = 1'b0;
      expRxV = 1'b0;
    end
    idle(2);
    monOn = 1'b0;
    checks++;
    if (txQ.size() != 0 || rxQ.size() != 0) begin
      errors++;
      $display("FAIL R4 pending actual=%0d expected=0", txQ.size() + rxQ.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule